// File: doc/BRIEF.md
# Synthesizer Power-Down Controller

This block sequences power-down for a frequency-synthesizer core. Three control bits arrive from a serial configuration register outside the block, presented here as parallel inputs: a power-down request, a mode select that picks between immediate and deferred entry, and a counter-reset bit. A write strobe marks the cycle in which a new word is latched. A chip-enable pin overrides the programmed bits and forces power-down whenever it is low.

In immediate mode the block powers down on the same clock edge that latches the request. In deferred mode it waits for the next charge-pump event pulse, which arrives once per phase-detector cycle, so the loop is not disturbed mid-correction. While powered down, the block drives the control lines the rest of the core obeys. These lines hold the reference, N and timeout counters at their load values, put the charge pump in three-state, reset lock detection, and switch off the input bias and the reference buffer. The configuration bits stay writable throughout power-down, so software can bring the core back up or change the mode.

Top module: `synth_pwrdn_ctrl`

## Requirements
- R1: With chip-enable low at a clock edge, the power-down flag is 1 after that edge, whatever the latched or incoming bits hold.
- R2: A word written with request=1 and mode=0 (immediate) while chip-enable is high sets the power-down flag at the edge that latches it.
- R3: A word written with request=1 and mode=1 (deferred) does not power the block down until an edge at which the charge-pump event input is 1.
- R4: A deferred word written in the same cycle as a charge-pump event powers down at that edge.
- R5: Whenever the power-down flag is 1, the timeout-counter load, charge-pump three-state, lock-detect reset, bias disable and reference-buffer disable outputs are all 1, and the R/N counter hold is 1. While the flag is 0, these five outputs are 0.
- R6: Words written while powered down are latched, and their bits take effect in the usual way.
- R7: A latched counter-reset bit of 1 drives the R/N counter hold to 1 even while powered up, without touching the timeout-counter load. The hold returns to 0 once a word clears the bit.
- R8: With chip-enable high, a latched request bit of 0 leaves power-down at the next clock edge.
- R9: Clearing the request bit before the charge-pump event cancels a pending deferred power-down. A clearing write in the same cycle as the event wins.
- R10: Reset clears the latched bits and the power-down flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| chip_en_i | input | 1 | Chip-enable pin; low forces power-down |
| word_wr_i | input | 1 | Latch strobe for the three configuration bits |
| pd_req_i | input | 1 | Power-down request bit |
| pd_sync_i | input | 1 | Mode: 0 immediate, 1 deferred to charge-pump event |
| cnt_rst_i | input | 1 | Counter-reset bit for the R and N counters |
| cp_evt_i | input | 1 | Charge-pump event pulse, one per phase-detector cycle |
| pd_state_o | output | 1 | Registered power-down flag |
| rn_cnt_hold_o | output | 1 | Holds R and N counters at their load state |
| tmo_cnt_load_o | output | 1 | Holds the timeout counter at its load state |
| cp_tristate_o | output | 1 | Forces the charge pump into three-state |
| lock_det_rst_o | output | 1 | Resets lock-detect logic |
| bias_off_o | output | 1 | Removes the input bias |
| refbuf_off_o | output | 1 | Disables the reference buffer |

## Verification
A configuration write and a charge-pump event can arrive in the same cycle. These coincidences decide whether a deferred request is taken at once or a cancellation wins. The bench drives the strobe and the event pulse on the same negative edge in two cases. In one, the written word is a deferred request, and the flag must be 1 after the next edge. In the other, the written word clears a pending deferred request, and the flag must stay 0 both after that edge and after a later lone event.

// File: rtl/synth_pwrdn_ctrl.sv
module synth_pwrdn_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chip_en_i,
  input  logic word_wr_i,
  input  logic pd_req_i,
  input  logic pd_sync_i,
  input  logic cnt_rst_i,
  input  logic cp_evt_i,
  output logic pd_state_o,
  output logic rn_cnt_hold_o,
  output logic tmo_cnt_load_o,
  output logic cp_tristate_o,
  output logic lock_det_rst_o,
  output logic bias_off_o,
  output logic refbuf_off_o
);

  logic req_q, sync_q, crst_q, pd_q;
  logic req_eff, sync_eff, crst_eff, pd_d;

  assign req_eff  = word_wr_i ? pd_req_i  : req_q;
  assign sync_eff = word_wr_i ? pd_sync_i : sync_q;
  assign crst_eff = word_wr_i ? cnt_rst_i : crst_q;

  always_comb begin
    if (!chip_en_i)     pd_d = 1'b1;
    else if (!req_eff)  pd_d = 1'b0;
    else if (!sync_eff) pd_d = 1'b1;
    else                pd_d = pd_q | cp_evt_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      sync_q <= 1'b0;
      crst_q <= 1'b0;
      pd_q   <= 1'b0;
    end else begin
      req_q  <= req_eff;
      sync_q <= sync_eff;
      crst_q <= crst_eff;
      pd_q   <= pd_d;
    end
  end

  assign pd_state_o     = pd_q;
  assign rn_cnt_hold_o  = pd_q | crst_q;
  assign tmo_cnt_load_o = pd_q;
  assign cp_tristate_o  = pd_q;
  assign lock_det_rst_o = pd_q;
  assign bias_off_o     = pd_q;
  assign refbuf_off_o   = pd_q;

endmodule

// File: rtl/synth_pwrdn_ctrl_chk.sv
module synth_pwrdn_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic chip_en_i,
  input logic word_wr_i,
  input logic pd_req_i,
  input logic pd_sync_i,
  input logic cnt_rst_i,
  input logic cp_evt_i,
  input logic pd_state_o,
  input logic rn_cnt_hold_o,
  input logic tmo_cnt_load_o,
  input logic cp_tristate_o,
  input logic lock_det_rst_o,
  input logic bias_off_o,
  input logic refbuf_off_o
);

  // R1
  ce_low_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_en_i |=> pd_state_o);

  // R2
  imm_write_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_en_i && word_wr_i && pd_req_i && !pd_sync_i |=> pd_state_o);

  // R3
  sync_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_en_i && word_wr_i && pd_req_i && pd_sync_i && !cp_evt_i && !pd_state_o
    |=> !pd_state_o);

  // R4
  sync_coincide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_en_i && word_wr_i && pd_req_i && pd_sync_i && cp_evt_i |=> pd_state_o);

  // R5
  pd_outputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_state_o |-> tmo_cnt_load_o && cp_tristate_o && lock_det_rst_o &&
                   bias_off_o && refbuf_off_o && rn_cnt_hold_o);

  // R7
  cnt_rst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_wr_i && cnt_rst_i |=> rn_cnt_hold_o);

  // R8
  req_clear_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_en_i && word_wr_i && !pd_req_i |=> !pd_state_o);

endmodule

bind synth_pwrdn_ctrl synth_pwrdn_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .chip_en_i(chip_en_i), .word_wr_i(word_wr_i),
  .pd_req_i(pd_req_i), .pd_sync_i(pd_sync_i), .cnt_rst_i(cnt_rst_i),
  .cp_evt_i(cp_evt_i), .pd_state_o(pd_state_o), .rn_cnt_hold_o(rn_cnt_hold_o),
  .tmo_cnt_load_o(tmo_cnt_load_o), .cp_tristate_o(cp_tristate_o),
  .lock_det_rst_o(lock_det_rst_o), .bias_off_o(bias_off_o),
  .refbuf_off_o(refbuf_off_o)
);

// File: tb/synth_pwrdn_ctrl_bench.sv
`timescale 1ns/1ps
module synth_pwrdn_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b1, wr = 1'b0, req = 1'b0, sync = 1'b0, crst = 1'b0, evt = 1'b0;
  logic pd, rnh, tmo, cpt, ldr, bia, rbf;

  int n_tests = 0, n_fail = 0;

  typedef struct {
    logic  pd;
    logic  rn;
    string tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_pwrdn_ctrl u_synth_pwrdn_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .chip_en_i(ce), .word_wr_i(wr),
    .pd_req_i(req), .pd_sync_i(sync), .cnt_rst_i(crst), .cp_evt_i(evt),
    .pd_state_o(pd), .rn_cnt_hold_o(rnh), .tmo_cnt_load_o(tmo),
    .cp_tristate_o(cpt), .lock_det_rst_o(ldr), .bias_off_o(bia),
    .refbuf_off_o(rbf)
  );

  task automatic check(input string tag, input string what, input logic [4:0] act, input logic [4:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic w, input logic r, input logic s,
                      input logic f, input logic e, input logic xpd, input logic xrn,
                      input string tag);
    @(negedge clk);
    ce = c; wr = w; req = r; sync = s; crst = f; evt = e;
    q.push_back('{pd: xpd, rn: xrn, tag: tag});
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      check(x.tag, "pd_state", {4'b0, pd}, {4'b0, x.pd});
      check(x.tag, "rn_hold", {4'b0, rnh}, {4'b0, x.rn});
      check(x.tag, "pd_outputs R5", {tmo, cpt, ldr, bia, rbf}, {5{x.pd}});
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R10", "reset pd/rn", {3'b0, pd, rnh}, 5'b0);
    @(negedge clk);
    rst_n = 1'b1;
    //    ce wr rq sy cr ev  pd rn
    step(1, 0, 0, 0, 0, 0,  0, 0, "R10 idle after reset");
    step(1, 1, 1, 0, 0, 0,  1, 1, "R2 immediate write");
    step(1, 0, 0, 0, 0, 0,  1, 1, "R5 held down");
    step(1, 1, 0, 0, 1, 0,  0, 1, "R8 R6 R7 exit with counter reset");
    step(1, 0, 0, 0, 0, 0,  0, 1, "R7 hold while up");
    step(1, 1, 0, 0, 0, 0,  0, 0, "R7 counter reset cleared");
    step(1, 1, 1, 1, 0, 0,  0, 0, "R3 deferred write");
    step(1, 0, 0, 0, 0, 0,  0, 0, "R3 waiting for event");
    step(1, 0, 0, 0, 0, 1,  1, 1, "R3 event powers down");
    step(1, 0, 0, 0, 0, 0,  1, 1, "R3 stays down");
    step(1, 1, 0, 0, 0, 0,  0, 0, "R8 exit");
    step(1, 1, 1, 1, 0, 0,  0, 0, "R9 deferred pending");
    step(1, 1, 0, 1, 0, 1,  0, 0, "R9 clear wins over event");
    step(1, 0, 0, 0, 0, 1,  0, 0, "R9 later event ignored");
    step(1, 1, 1, 1, 0, 1,  1, 1, "R4 write with event");
    step(1, 1, 0, 0, 0, 0,  0, 0, "R8 exit again");
    step(0, 0, 0, 0, 0, 0,  1, 1, "R1 chip-enable low");
    step(0, 0, 0, 0, 0, 1,  1, 1, "R1 event while disabled");
    step(0, 1, 1, 0, 0, 0,  1, 1, "R6 write while disabled");
    step(1, 0, 0, 0, 0, 0,  1, 1, "R6 latched request keeps down");
    step(1, 1, 0, 0, 0, 0,  0, 0, "R8 request cleared");
    step(0, 1, 0, 0, 1, 0,  1, 1, "R1 R6 counter reset written while disabled");
    step(1, 0, 0, 0, 0, 0,  0, 1, "R7 R6 counter reset latched in power-down");
    step(1, 1, 1, 1, 0, 0,  0, 0, "R3 deferred after disable");
    step(0, 0, 0, 0, 0, 0,  1, 1, "R1 overrides pending deferred");
    step(1, 1, 0, 0, 0, 0,  0, 0, "R8 final exit");
    @(negedge clk);
    wr = 1'b0; evt = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule